// File: doc/BRIEF.md
# Compare-Triggered Conversion Start Controller

This block couples two 16-bit up-counters, a 16-bit compare value and the start/busy handshake of an analog-to-digital converter. When the compare mode field selects the special-event setting and the chosen counter equals the compare value, the block clears that counter. In the same clock edge it starts a conversion, provided the converter is enabled and idle. The counter period therefore repeats with no software action, and each period can launch one sample.

A started conversion waits a programmable acquisition time and then runs a fixed twelve-tick conversion. Both are counted in converter ticks, and a clock-select field sets the tick period. A behavioural converter stub takes the 12-bit input value at the end of acquisition. When the conversion ends, the block loads that value into a result register, drops the busy flag and raises an interrupt flag. The flag stays set until software clears it. Software can also start a conversion directly. The result can be read right-aligned or left-aligned as two bytes.

Top module: `evt_conv_ctrl`

## Requirements
- R1: With `cmp_mode` equal to 4'b1011 and the selected counter equal to `cmp_value`, `event_hit` is high in that cycle. At the next edge the selected counter is cleared, so it reads 0 in the following cycle.
- R2: With any other `cmp_mode` value, a counter that equals `cmp_value` is not cleared. It keeps counting and no conversion starts.
- R3: A special event while `conv_en` is 1 and `busy` is 0 makes `busy` read 1 in the next cycle.
- R4: A special event while `conv_en` is 0 still clears the selected counter, but `busy` stays 0.
- R5: `busy` stays high for exactly (A + 12) * 2^`clk_sel` cycles. A is 0, 2, 4, 6, 8, 12, 16 or 20 for `acq_sel` values 0 to 7.
- R6: `busy` falls, the result register loads the `sample_in` value taken at the end of acquisition, and `irq_flag` rises, all on the same edge.
- R7: With `left_just` = 0, `res_hi` = {4'b0, r[11:8]} and `res_lo` = r[7:0]. With `left_just` = 1, `res_hi` = r[11:4] and `res_lo` = {r[3:0], 4'b0}. Here r is the stored 12-bit result.
- R8: `irq_flag` stays set until a cycle with `irq_clr` high. It then reads 0 from the next cycle. A completion in the same cycle as the clear wins.
- R9: `timer_sel` = 0 selects counter A and 1 selects counter B for the compare and the clear. The other counter is never cleared. Each counter adds one per cycle while its count enable is high.
- R10: A special event while `busy` is 1 does not restart or lengthen the conversion, but it still clears the counter.
- R11: A `sw_start` pulse while idle with `conv_en` = 1 runs the same sequence as R5 and R6. A `sw_start` pulse while busy has no effect on the duration.
- R12: During reset both counters, `busy`, `irq_flag`, `res_hi` and `res_lo` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en_a | input | 1 | Count enable of counter A |
| cnt_en_b | input | 1 | Count enable of counter B |
| timer_sel | input | 1 | 0: counter A feeds the compare, 1: counter B |
| cmp_mode | input | 4 | Compare mode, 4'b1011 is the special event |
| cmp_value | input | 16 | Compare value |
| conv_en | input | 1 | Converter enable |
| sw_start | input | 1 | Software start pulse |
| acq_sel | input | 3 | Acquisition time select |
| clk_sel | input | 3 | Converter tick period, 2^clk_sel cycles |
| left_just | input | 1 | Result alignment |
| irq_clr | input | 1 | Clears the interrupt flag |
| sample_in | input | 12 | Value seen by the converter stub |
| timer_a | output | 16 | Counter A value |
| timer_b | output | 16 | Counter B value |
| busy | output | 1 | Conversion in progress (go/done) |
| irq_flag | output | 1 | Conversion complete flag |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| event_hit | output | 1 | Special-event compare match this cycle |

## Verification
Some rules hold on every cycle, and the bound checker tests them all the time. The selected counter reads zero after a special event, and the other counter keeps counting. Non-special modes never clear a counter. An enabled idle event raises busy, and a disabled one leaves it low. The interrupt flag rises only as busy falls, and it stays set until a clear. The exact busy length for each acquisition and tick setting needs directed scenarios. So do the captured and aligned result bytes, retriggering during a long conversion, and software starts that are ignored while busy.

// File: rtl/evt_conv_pkg.sv
package evt_conv_pkg;

    localparam int TMR_W      = 16;
    localparam int MODE_W     = 4;
    localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;
    localparam int ACQ_SEL_W  = 3;
    localparam int CLK_SEL_W  = 3;
    localparam int DIV_W      = (2 ** CLK_SEL_W) - 1;
    localparam int PH_W       = 5;
    localparam int CONV_TICKS = 12;
    localparam int RES_W      = 12;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [DIV_W-1:0]  div_cnt;
        logic [DIV_W-1:0]  div_lim;
        logic [PH_W-1:0]   ph_cnt;
        logic [PH_W-1:0]   acq_len;
    } seq_t;

    function automatic logic [PH_W-1:0] acq_ticks(input logic [ACQ_SEL_W-1:0] sel);
        logic [PH_W-1:0] t;
        case (sel)
            3'd0:    t = 5'd0;
            3'd1:    t = 5'd2;
            3'd2:    t = 5'd4;
            3'd3:    t = 5'd6;
            3'd4:    t = 5'd8;
            3'd5:    t = 5'd12;
            3'd6:    t = 5'd16;
            default: t = 5'd20;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/evt_timer_pair.sv
module evt_timer_pair #(
    parameter int TW = 16,
    parameter int NT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT-1:0]         cnt_en,
    input  logic [NT-1:0]         clr,
    output logic [NT-1:0][TW-1:0] cnt
);

    logic [NT-1:0][TW-1:0] cnt_d, cnt_q;

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        always_comb begin
            cnt_d[i] = cnt_q[i];
            if (clr[i]) begin
                cnt_d[i] = '0;
            end else if (cnt_en[i]) begin
                cnt_d[i] = cnt_q[i] + TW'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d[i];
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/evt_conv_seq.sv
module evt_conv_seq
    import evt_conv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ACQ_SEL_W-1:0] acq_sel,
    input  logic [CLK_SEL_W-1:0] clk_sel,
    output logic                 busy,
    output logic                 sample_now,
    output logic                 done
);

    seq_t seq_d, seq_q;
    logic tick;
    logic [PH_W-1:0] ph_inc;
    logic [PH_W-1:0] start_acq;
    logic [DIV_W-1:0] start_lim;

    assign tick      = (seq_q.div_cnt == seq_q.div_lim);
    assign ph_inc    = seq_q.ph_cnt + PH_W'(1);
    assign start_acq = acq_ticks(acq_sel);
    assign start_lim = DIV_W'((8'd1 << clk_sel) - 8'd1);

    always_comb begin
        seq_d      = seq_q;
        sample_now = 1'b0;
        done       = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.div_cnt = '0;
                    seq_d.ph_cnt  = '0;
                    seq_d.div_lim = start_lim;
                    seq_d.acq_len = start_acq;
                    if (start_acq == '0) begin
                        seq_d.state = SEQ_CONV;
                        sample_now  = 1'b1;
                    end else begin
                        seq_d.state = SEQ_ACQ;
                    end
                end
            end
            SEQ_ACQ: begin
                if (tick) begin
                    seq_d.div_cnt = '0;
                    if (ph_inc == seq_q.acq_len) begin
                        seq_d.state  = SEQ_CONV;
                        seq_d.ph_cnt = '0;
                        sample_now   = 1'b1;
                    end else begin
                        seq_d.ph_cnt = ph_inc;
                    end
                end else begin
                    seq_d.div_cnt = seq_q.div_cnt + DIV_W'(1);
                end
            end
            SEQ_CONV: begin
                if (tick) begin
                    seq_d.div_cnt = '0;
                    if (ph_inc == PH_W'(CONV_TICKS)) begin
                        seq_d.state  = SEQ_IDLE;
                        seq_d.ph_cnt = '0;
                        done         = 1'b1;
                    end else begin
                        seq_d.ph_cnt = ph_inc;
                    end
                end else begin
                    seq_d.div_cnt = seq_q.div_cnt + DIV_W'(1);
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state   <= SEQ_IDLE;
            seq_q.div_cnt <= '0;
            seq_q.div_lim <= '0;
            seq_q.ph_cnt  <= '0;
            seq_q.acq_len <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.state != SEQ_IDLE);

endmodule

// File: rtl/evt_conv_stub.sv
module evt_conv_stub
    import evt_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_now,
    input  logic [RES_W-1:0] sample_in,
    output logic [RES_W-1:0] conv_out
);

    logic [RES_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (sample_now) hold_d = sample_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign conv_out = hold_q;

endmodule

// File: rtl/evt_result_reg.sv
module evt_result_reg
    import evt_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] conv_out,
    input  logic             left_just,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);

    localparam int PAD_W = 16 - RES_W;

    logic [RES_W-1:0] res_d, res_q;
    logic [15:0]      word;

    always_comb begin
        res_d = res_q;
        if (load) res_d = conv_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    always_comb begin
        if (left_just) word = {res_q, {PAD_W{1'b0}}};
        else           word = {{PAD_W{1'b0}}, res_q};
    end

    assign res_hi = word[15:8];
    assign res_lo = word[7:0];

endmodule

// File: rtl/evt_conv_ctrl.sv
module evt_conv_ctrl
    import evt_conv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en_a,
    input  logic                 cnt_en_b,
    input  logic                 timer_sel,
    input  logic [MODE_W-1:0]    cmp_mode,
    input  logic [TMR_W-1:0]     cmp_value,
    input  logic                 conv_en,
    input  logic                 sw_start,
    input  logic [ACQ_SEL_W-1:0] acq_sel,
    input  logic [CLK_SEL_W-1:0] clk_sel,
    input  logic                 left_just,
    input  logic                 irq_clr,
    input  logic [RES_W-1:0]     sample_in,
    output logic [TMR_W-1:0]     timer_a,
    output logic [TMR_W-1:0]     timer_b,
    output logic                 busy,
    output logic                 irq_flag,
    output logic [7:0]           res_hi,
    output logic [7:0]           res_lo,
    output logic                 event_hit
);

    logic [1:0][TMR_W-1:0] tmr;
    logic [1:0]            tmr_clr;
    logic [TMR_W-1:0]      sel_tmr;
    logic                  conv_start;
    logic                  sample_now;
    logic                  conv_done;
    logic [RES_W-1:0]      conv_out;
    logic                  irq_d, irq_q;

    assign sel_tmr   = timer_sel ? tmr[1] : tmr[0];
    assign event_hit = (cmp_mode == MODE_SPECIAL) && (sel_tmr == cmp_value);
    assign tmr_clr   = event_hit ? (timer_sel ? 2'b10 : 2'b01) : 2'b00;
    assign conv_start = conv_en && (event_hit || sw_start);

    evt_timer_pair #(.TW(TMR_W), .NT(2)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en ({cnt_en_b, cnt_en_a}),
        .clr    (tmr_clr),
        .cnt    (tmr)
    );

    evt_conv_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (conv_start),
        .acq_sel    (acq_sel),
        .clk_sel    (clk_sel),
        .busy       (busy),
        .sample_now (sample_now),
        .done       (conv_done)
    );

    evt_conv_stub u_stub (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now),
        .sample_in  (sample_in),
        .conv_out   (conv_out)
    );

    evt_result_reg u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (conv_done),
        .conv_out  (conv_out),
        .left_just (left_just),
        .res_hi    (res_hi),
        .res_lo    (res_lo)
    );

    always_comb begin
        irq_d = irq_q;
        if (conv_done)    irq_d = 1'b1;
        else if (irq_clr) irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign timer_a  = tmr[0];
    assign timer_b  = tmr[1];
    assign irq_flag = irq_q;

endmodule

// File: rtl/evt_conv_ctrl_chk.sv
module evt_conv_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_en_a,
    input logic        cnt_en_b,
    input logic        timer_sel,
    input logic [3:0]  cmp_mode,
    input logic [15:0] cmp_value,
    input logic        conv_en,
    input logic        sw_start,
    input logic        irq_clr,
    input logic [15:0] timer_a,
    input logic [15:0] timer_b,
    input logic        busy,
    input logic        irq_flag
);

    logic hit_a, hit_b, hit;
    assign hit_a = (cmp_mode == 4'b1011) && !timer_sel && (timer_a == cmp_value);
    assign hit_b = (cmp_mode == 4'b1011) &&  timer_sel && (timer_b == cmp_value);
    assign hit   = hit_a || hit_b;

    assert_clear_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> (timer_a == 16'd0));

    assert_clear_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> (timer_b == 16'd0));

    assert_other_mode_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode != 4'b1011 && cnt_en_a) |=> (timer_a == $past(timer_a) + 16'd1));

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && conv_en && !busy) |=> busy);

    assert_disabled_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !conv_en && !busy) |=> !busy);

    assert_irq_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(busy));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    assert_other_timer_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> (timer_b == $past(timer_b) + {15'd0, $past(cnt_en_b)}));

    assert_sw_idle_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && conv_en && !busy) |=> busy);

endmodule

bind evt_conv_ctrl evt_conv_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en_a  (cnt_en_a),
    .cnt_en_b  (cnt_en_b),
    .timer_sel (timer_sel),
    .cmp_mode  (cmp_mode),
    .cmp_value (cmp_value),
    .conv_en   (conv_en),
    .sw_start  (sw_start),
    .irq_clr   (irq_clr),
    .timer_a   (timer_a),
    .timer_b   (timer_b),
    .busy      (busy),
    .irq_flag  (irq_flag)
);

// File: tb/evt_conv_ctrl_test.sv
module evt_conv_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en_a = 1'b0, cnt_en_b = 1'b0, timer_sel = 1'b0;
    logic [3:0]  cmp_mode = 4'd0;
    logic [15:0] cmp_value = 16'hFFFF;
    logic        conv_en = 1'b0, sw_start = 1'b0, left_just = 1'b0, irq_clr = 1'b0;
    logic [2:0]  acq_sel = 3'd0, clk_sel = 3'd0;
    logic [11:0] sample_in = 12'd0;
    logic [15:0] timer_a, timer_b;
    logic        busy, irq_flag, event_hit;
    logic [7:0]  res_hi, res_lo;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    evt_conv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cnt_en_a(cnt_en_a), .cnt_en_b(cnt_en_b),
        .timer_sel(timer_sel), .cmp_mode(cmp_mode), .cmp_value(cmp_value),
        .conv_en(conv_en), .sw_start(sw_start), .acq_sel(acq_sel),
        .clk_sel(clk_sel), .left_just(left_just), .irq_clr(irq_clr),
        .sample_in(sample_in), .timer_a(timer_a), .timer_b(timer_b),
        .busy(busy), .irq_flag(irq_flag), .res_hi(res_hi), .res_lo(res_lo),
        .event_hit(event_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int acq_of(input logic [2:0] s);
        case (s)
            3'd0: return 0;  3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 20;
        endcase
    endfunction

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R8 clear", {31'd0, irq_flag}, 32'd0);
    endtask

    // Returns the number of cycles busy was observed high, starting at the current negedge.
    task automatic measure_busy(output int dur, output int zeros_a);
        dur = 0; zeros_a = 0;
        while (busy && dur < 5000) begin
            dur++;
            if (timer_a == 16'd0) zeros_a++;
            @(negedge clk);
        end
    endtask

    // Arms a match on the selected counter six cycles ahead and waits for it.
    task automatic wait_match(input logic sel);
        @(negedge clk);
        timer_sel = sel;
        cmp_value = (sel ? timer_b : timer_a) + 16'd6;
        for (int i = 0; i < 20; i++) begin
            if ((sel ? timer_b : timer_a) == cmp_value) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 timer_a", {16'd0, timer_a}, 32'd0);
        chk("R12 timer_b", {16'd0, timer_b}, 32'd0);
        chk("R12 busy", {31'd0, busy}, 32'd0);
        chk("R12 irq", {31'd0, irq_flag}, 32'd0);
        chk("R12 result", {16'd0, res_hi, res_lo}, 32'd0);
        rst_n = 1'b1;
        cnt_en_a = 1'b1; cnt_en_b = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_trigger_basic();
        int dur, z;
        conv_en = 1'b1; acq_sel = 3'd3; clk_sel = 3'd0; left_just = 1'b0;
        sample_in = 12'hA5C; cmp_mode = 4'b1011;
        wait_match(1'b0);
        chk("R1 event_hit", {31'd0, event_hit}, 32'd1);
        @(negedge clk);
        cmp_mode = 4'd0;
        chk("R1 timer cleared", {16'd0, timer_a}, 32'd0);
        chk("R3 busy after event", {31'd0, busy}, 32'd1);
        measure_busy(dur, z);
        chk("R5 duration acq6 div1", dur, (acq_of(3'd3) + 12) * 1);
        chk("R6 irq set", {31'd0, irq_flag}, 32'd1);
        chk("R6 R7 right hi", {24'd0, res_hi}, 32'h0A);
        chk("R6 R7 right lo", {24'd0, res_lo}, 32'h5C);
    endtask

    task automatic t_left_justify();
        @(negedge clk); left_just = 1'b1;
        @(negedge clk);
        chk("R7 left hi", {24'd0, res_hi}, 32'hA5);
        chk("R7 left lo", {24'd0, res_lo}, 32'hC0);
        left_just = 1'b0;
    endtask

    task automatic t_irq_hold();
        repeat (5) @(negedge clk);
        chk("R8 irq held", {31'd0, irq_flag}, 32'd1);
        clear_irq();
    endtask

    task automatic t_other_mode();
        logic [15:0] m;
        cmp_mode = 4'b1010;
        wait_match(1'b0);
        m = timer_a;
        @(negedge clk);
        chk("R2 timer not cleared", {16'd0, timer_a}, {16'd0, m + 16'd1});
        chk("R2 no start", {31'd0, busy}, 32'd0);
        cmp_mode = 4'd0;
    endtask

    task automatic t_disabled();
        conv_en = 1'b0; cmp_mode = 4'b1011;
        wait_match(1'b0);
        @(negedge clk);
        cmp_mode = 4'd0;
        chk("R4 timer cleared", {16'd0, timer_a}, 32'd0);
        chk("R4 busy stays low", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R4 irq stays low", {31'd0, irq_flag}, 32'd0);
        conv_en = 1'b1;
    endtask

    task automatic t_timer_b();
        int dur, z;
        logic [15:0] a;
        acq_sel = 3'd0; clk_sel = 3'd0; sample_in = 12'h3C7; cmp_mode = 4'b1011;
        wait_match(1'b1);
        a = timer_a;
        @(negedge clk);
        cmp_mode = 4'd0;
        chk("R9 timer_b cleared", {16'd0, timer_b}, 32'd0);
        chk("R9 timer_a kept", {16'd0, timer_a}, {16'd0, a + 16'd1});
        chk("R9 busy", {31'd0, busy}, 32'd1);
        measure_busy(dur, z);
        chk("R5 duration acq0", dur, 12);
        chk("R6 result lo", {24'd0, res_lo}, 32'hC7);
        timer_sel = 1'b0;
        clear_irq();
    endtask

    task automatic t_retrigger();
        int dur, z;
        acq_sel = 3'd7; clk_sel = 3'd2; cmp_mode = 4'b1011;
        wait_match(1'b0);
        @(negedge clk);
        cmp_value = 16'd5;
        measure_busy(dur, z);
        cmp_mode = 4'd0;
        chk("R10 no restart", dur, (acq_of(3'd7) + 12) * 4);
        chk("R10 counter still cleared", {31'd0, (z >= 10)}, 32'd1);
        chk("R6 irq after long run", {31'd0, irq_flag}, 32'd1);
        clear_irq();
    endtask

    task automatic t_sw_start();
        int dur, z;
        acq_sel = 3'd0; clk_sel = 3'd1; sample_in = 12'h19E;
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        chk("R11 sw busy", {31'd0, busy}, 32'd1);
        repeat (5) @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        measure_busy(dur, z);
        chk("R11 duration ignoring restart", dur + 6, 12 * 2);
        chk("R11 result hi", {24'd0, res_hi}, 32'h01);
        chk("R11 irq", {31'd0, irq_flag}, 32'd1);
        clear_irq();
    endtask

    initial begin
        t_reset();
        t_trigger_basic();
        t_left_justify();
        t_irq_hold();
        t_other_mode();
        t_disabled();
        t_timer_b();
        t_retrigger();
        t_sw_start();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule